// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter

This block serialises one byte at a time onto a single transmit line using an asynchronous start/stop framing. A producer hands over a byte on a valid/ready handshake. The block then drives a low start bit, the data bits with the least significant bit first, an optional parity bit and one or two high stop bits. The line rests high between characters.

The character shape comes from a mode register, and the bit period from a clock-select field in that register together with an 8-bit rate register. Each bit lasts 32 × 4^n × (N+1) clock cycles, where n is the clock-select value and N is the rate value. Both registers can be written at any time. The block copies them when it accepts a byte, so a write made during a character applies from the next character on.

A one-cycle completion pulse marks the end of the last stop bit. In that same cycle the block can accept the next byte, so characters can follow each other with a single idle cycle between them.

Top module: `async_frame_tx`

## Requirements
- R1: After reset, tx_o is high, tx_ready_o is high and done_o is low.
- R2: On the edge where tx_valid_i and tx_ready_o are both high, the byte is accepted. From the next cycle, tx_ready_o is low and tx_o drives the start bit (low), followed by the data bits with bit 0 first.
- R3: Mode bit 6 set gives 7 data bits (data bit 7 is not sent). Mode bit 6 clear gives 8 data bits.
- R4: Mode bit 5 set appends a parity bit after the data bits. Mode bit 4 chooses the parity: 1 is odd and 0 is even, counted over the data bits that are sent.
- R5: Mode bit 3 set gives two high stop bits. Mode bit 3 clear gives one.
- R6: Every bit of a frame lasts 32 × 4^n × (N+1) clock cycles. Here n is mode bits 1:0 (0 = clock/1, 1 = /4, 2 = /16, 3 = /64) and N is the rate register.
- R7: Reset leaves the mode register at 0 and the rate register at 0xFF. A byte sent with no register write therefore goes out as 8 data bits, no parity and one stop bit, with 8192-cycle bits.
- R8: A mode or rate write made while a frame is in flight leaves that frame unchanged. The new settings apply from the next accepted byte.
- R9: done_o is high for exactly one cycle, the cycle after the last stop bit ends, and tx_ready_o is high in that same cycle. A byte offered in that cycle is accepted at the next edge.
- R10: tx_data_i and tx_valid_i are sampled only on the accepting edge. Changes to them during a frame do not alter the bits sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_wr_i | input | 1 | Write strobe for the mode register |
| mode_i | input | 8 | Mode value: bit 6 selects 7-bit data, bit 5 enables parity, bit 4 selects odd parity, bit 3 selects two stop bits, bits 1:0 select the clock |
| rate_wr_i | input | 1 | Write strobe for the rate register |
| rate_i | input | 8 | Rate divider value N |
| tx_valid_i | input | 1 | Byte offered |
| tx_data_i | input | 8 | Byte to send |
| tx_ready_o | output | 1 | Idle; a byte offered now is accepted |
| tx_o | output | 1 | Serial transmit line |
| done_o | output | 1 | One-cycle pulse at the end of the last stop bit |

## Verification
The assertions assume that all inputs are synchronous to clk_i and hold known values after reset. They also assume that a byte is counted as accepted only when tx_valid_i and tx_ready_o are high on the same edge. The bench changes every input on the falling clock edge. It raises tx_valid_i for exactly one accepting edge per byte. It then scrambles tx_data_i and may write the registers while the frame is running, which keeps every input change clear of the sampling edge while still testing that mid-frame changes have no effect.

// File: rtl/afx_pkg.sv
package afx_pkg;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = 12;
  localparam int LEN_W   = 4;

  typedef struct packed {
    logic       chr7;
    logic       par_en;
    logic       par_odd;
    logic       stop2;
    logic [1:0] cks;
  } mode_t;

  typedef struct packed {
    logic [FRAME_W-1:0] bits;
    logic [LEN_W-1:0]   len;
  } frame_t;

  function automatic mode_t decode_mode(input logic [7:0] m);
    mode_t r;
    r.chr7    = m[6];
    r.par_en  = m[5];
    r.par_odd = m[4];
    r.stop2   = m[3];
    r.cks     = m[1:0];
    return r;
  endfunction

  // bit 0 of bits is the first bit on the line; unused tail stays high
  function automatic frame_t build_frame(input logic [DATA_W-1:0] d, input mode_t m);
    frame_t f;
    int     pos;
    logic   par;
    f.bits    = '1;
    f.bits[0] = 1'b0;
    pos       = 1;
    par       = m.par_odd;
    for (int i = 0; i < DATA_W; i++) begin
      if (!(m.chr7 && i == DATA_W - 1)) begin
        f.bits[pos] = d[i];
        par         = par ^ d[i];
        pos         = pos + 1;
      end
    end
    if (m.par_en) begin
      f.bits[pos] = par;
      pos         = pos + 1;
    end
    pos   = pos + (m.stop2 ? 2 : 1);
    f.len = LEN_W'(pos);
    return f;
  endfunction
endpackage

// File: rtl/afx_prescaler.sv
module afx_prescaler #(
  parameter int CKS_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [CKS_W-1:0] cks_i,
  output logic             tick_o
);
  localparam int CNT_W = 2 * ((1 << CKS_W) - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  assign lim    = CNT_W'((1 << (2 * int'(cks_i))) - 1);
  assign tick_o = en_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/afx_bit_timer.sv
module afx_bit_timer #(
  parameter int RATE_W      = 8,
  parameter int BASE_FACTOR = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              tick_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              bit_end_o
);
  localparam int CNT_W = $clog2(BASE_FACTOR * (1 << RATE_W));

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  assign lim       = CNT_W'(BASE_FACTOR * (int'(rate_i) + 1) - 1);
  assign bit_end_o = tick_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (clr_i)     cnt_q <= '0;
    else if (bit_end_o) cnt_q <= '0;
    else if (tick_i)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/afx_framer.sv
module afx_framer #(
  parameter int FRAME_W = 12,
  parameter int LEN_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] bits_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic               step_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               tx_o
);
  logic [FRAME_W-1:0] sh_q;
  logic [LEN_W-1:0]   rem_q;
  logic               busy_q;
  logic               done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      rem_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_i) begin
        sh_q   <= bits_i;
        rem_q  <= len_i;
        busy_q <= 1'b1;
      end else if (step_i && busy_q) begin
        sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
        rem_q <= rem_q - 1'b1;
        if (rem_q == LEN_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign tx_o   = !busy_q || sh_q[0];
endmodule

// File: rtl/async_frame_tx.sv
module async_frame_tx #(
  parameter int RATE_W      = 8,
  parameter int CKS_W       = 2,
  parameter int BASE_FACTOR = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mode_wr_i,
  input  logic [7:0] mode_i,
  input  logic       rate_wr_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic       tx_valid_i,
  input  logic [afx_pkg::DATA_W-1:0] tx_data_i,
  output logic       tx_ready_o,
  output logic       tx_o,
  output logic       done_o
);
  import afx_pkg::*;

  mode_t             mode_q, cfg_mode_q;
  logic [RATE_W-1:0] rate_q, cfg_rate_q;
  logic              busy, accept, tick, bit_end;
  frame_t            frame;

  assign tx_ready_o = !busy;
  assign accept     = tx_valid_i && tx_ready_o;
  assign frame      = build_frame(tx_data_i, mode_q);

  // software-visible settings
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      rate_q <= '1;
    end else begin
      if (mode_wr_i) mode_q <= decode_mode(mode_i);
      if (rate_wr_i) rate_q <= rate_i;
    end
  end

  // per-frame snapshot, so writes never disturb a character in flight
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_mode_q <= '0;
      cfg_rate_q <= '1;
    end else if (accept) begin
      cfg_mode_q <= mode_q;
      cfg_rate_q <= rate_q;
    end
  end

  afx_prescaler #(.CKS_W(CKS_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .en_i   (busy),
    .cks_i  (cfg_mode_q.cks),
    .tick_o (tick)
  );

  afx_bit_timer #(.RATE_W(RATE_W), .BASE_FACTOR(BASE_FACTOR)) u_bt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (accept),
    .tick_i    (tick),
    .rate_i    (cfg_rate_q),
    .bit_end_o (bit_end)
  );

  afx_framer #(.FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_fr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .bits_i (frame.bits),
    .len_i  (frame.len),
    .step_i (bit_end),
    .busy_o (busy),
    .done_o (done_o),
    .tx_o   (tx_o)
  );
endmodule

// File: rtl/async_frame_tx_checks.sv
module async_frame_tx_checks (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_valid_i,
  input logic tx_ready_o,
  input logic tx_o,
  input logic done_o
);
  a_r1_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> tx_o);

  a_r2_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && tx_ready_o) |=> (!tx_o && !tx_ready_o));

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_ready_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> tx_ready_o);

  a_r9_ready_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_ready_o) |-> done_o);
endmodule

bind async_frame_tx async_frame_tx_checks u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tx_valid_i (tx_valid_i),
  .tx_ready_o (tx_ready_o),
  .tx_o       (tx_o),
  .done_o     (done_o)
);

// File: tb/async_frame_tx_bench.sv
module async_frame_tx_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_wr_i = 1'b0;
  logic [7:0] mode_i = '0;
  logic       rate_wr_i = 1'b0;
  logic [7:0] rate_i = '0;
  logic       tx_valid_i = 1'b0;
  logic [7:0] tx_data_i = '0;
  logic       tx_ready_o, tx_o, done_o;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  async_frame_tx u_async_frame_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_wr_i  (mode_wr_i),
    .mode_i     (mode_i),
    .rate_wr_i  (rate_wr_i),
    .rate_i     (rate_i),
    .tx_valid_i (tx_valid_i),
    .tx_data_i  (tx_data_i),
    .tx_ready_o (tx_ready_o),
    .tx_o       (tx_o),
    .done_o     (done_o)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] m, input logic [7:0] r);
    mode_wr_i = 1'b1; mode_i = m;
    rate_wr_i = 1'b1; rate_i = r;
    @(negedge clk_i);
    mode_wr_i = 1'b0;
    rate_wr_i = 1'b0;
  endtask

  // Called at a falling edge. m/r are the settings the frame must use.
  task automatic send(input logic [7:0] d, input logic [7:0] m, input logic [7:0] r,
                      input string tag, input bit poke,
                      input logic [7:0] pm, input logic [7:0] pr);
    logic exp_bits[12];
    int   len, per, now, tgt, dl;
    logic par;
    dl  = m[6] ? 7 : 8;
    par = m[4];
    exp_bits[0] = 1'b0;
    len = 1;
    for (int i = 0; i < dl; i++) begin
      exp_bits[len] = d[i];
      par = par ^ d[i];
      len++;
    end
    if (m[5]) begin exp_bits[len] = par; len++; end
    exp_bits[len] = 1'b1; len++;
    if (m[3]) begin exp_bits[len] = 1'b1; len++; end
    per = 32 * (1 << (2 * int'(m[1:0]))) * (int'(r) + 1);

    tx_valid_i = 1'b1;
    tx_data_i  = d;
    @(posedge clk_i);
    @(negedge clk_i);
    now = 1;
    tx_valid_i = 1'b0;
    tx_data_i  = ~d;            // R10: must not leak into the frame
    check("R2", "ready after accept", int'(tx_ready_o), 0);
    check("R9", "done pulse width", int'(done_o), 0);
    if (poke) begin
      mode_wr_i = 1'b1; mode_i = pm;
      rate_wr_i = 1'b1; rate_i = pr;
    end
    @(negedge clk_i);
    now = 2;
    mode_wr_i = 1'b0;
    rate_wr_i = 1'b0;
    for (int k = 0; k < len; k++) begin
      tgt = k * per + per / 2;
      repeat (tgt - now) @(negedge clk_i);
      now = tgt;
      check(tag, $sformatf("bit %0d", k), int'(tx_o), int'(exp_bits[k]));
    end
    repeat (len * per - now) @(negedge clk_i);
    now = len * per;
    check("R9", "busy in last stop cycle", int'(tx_ready_o), 0);
    check("R6", "line in last stop cycle", int'(tx_o), 1);
    @(negedge clk_i);
    check("R9", "done at frame end", int'(done_o), 1);
    check("R9", "ready with done", int'(tx_ready_o), 1);
    check("R5", "idle high after stop", int'(tx_o), 1);
  endtask

  task automatic t_reset;
    check("R1", "tx idle", int'(tx_o), 1);
    check("R1", "ready", int'(tx_ready_o), 1);
    check("R1", "done", int'(done_o), 0);
  endtask

  task automatic t_reset_cfg;
    send(8'hA5, 8'h00, 8'hFF, "R7", 1'b0, 8'h00, 8'h00);
  endtask

  task automatic t_basic;
    write_cfg(8'h00, 8'h00);
    send(8'h3C, 8'h00, 8'h00, "R2", 1'b0, 8'h00, 8'h00);
    send(8'h81, 8'h00, 8'h00, "R2", 1'b0, 8'h00, 8'h00);   // back-to-back, R9
  endtask

  task automatic t_chr7;
    write_cfg(8'h40, 8'h00);
    send(8'hFF, 8'h40, 8'h00, "R3", 1'b0, 8'h00, 8'h00);
    send(8'h55, 8'h40, 8'h00, "R3", 1'b0, 8'h00, 8'h00);
  endtask

  task automatic t_parity;
    write_cfg(8'h20, 8'h00);
    send(8'h07, 8'h20, 8'h00, "R4", 1'b0, 8'h00, 8'h00);
    write_cfg(8'h30, 8'h00);
    send(8'h07, 8'h30, 8'h00, "R4", 1'b0, 8'h00, 8'h00);
    write_cfg(8'h70, 8'h00);
    send(8'h80, 8'h70, 8'h00, "R4", 1'b0, 8'h00, 8'h00);
  endtask

  task automatic t_stop;
    write_cfg(8'h08, 8'h00);
    send(8'hC3, 8'h08, 8'h00, "R5", 1'b0, 8'h00, 8'h00);
    write_cfg(8'h78, 8'h00);
    send(8'h5A, 8'h78, 8'h00, "R5", 1'b0, 8'h00, 8'h00);
  endtask

  task automatic t_prescale;
    write_cfg(8'h01, 8'h01);
    send(8'h96, 8'h01, 8'h01, "R6", 1'b0, 8'h00, 8'h00);
    write_cfg(8'h02, 8'h00);
    send(8'h69, 8'h02, 8'h00, "R6", 1'b0, 8'h00, 8'h00);
    write_cfg(8'h03, 8'h00);
    send(8'hF0, 8'h03, 8'h00, "R6", 1'b0, 8'h00, 8'h00);
  endtask

  task automatic t_midframe;
    write_cfg(8'h00, 8'h00);
    send(8'h2D, 8'h00, 8'h00, "R8", 1'b1, 8'h48, 8'h03);
    send(8'hB4, 8'h48, 8'h03, "R8", 1'b0, 8'h00, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_reset_cfg();
    t_basic();
    t_chr7();
    t_parity();
    t_stop();
    t_prescale();
    t_midframe();
    repeat (4) @(negedge clk_i);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule